// File: doc/BRIEF.md
# DMA Request Router with Tiered Arbitration

This block sits between a large population of peripheral request lines and a smaller pool of DMA channels. Each request line owns a small mapping register that says whether the line is routed at all and, if so, to which channel. The routed requests form a per-channel request vector, and an arbiter hands the bus to exactly one requesting channel at a time.

Channels are ranked by four fixed priority tiers taken from their index, and channels that share a tier take turns. A grant is held until its owner either drops its request or signals the end of its burst, so a burst is never cut short by a more urgent channel. A registered summary vector mirrors the per-channel interrupt-pending inputs for the interrupt controller.

Software programs the mappings through a simple write port. The register for request line n sits at byte address 0x100 + 4·n for n below 64 and at 0x1100 + 4·(n − 64) for the upper bank.

Top module: `dreq_prio_router`

## Requirements
- R1: While reset is asserted and after its release, all mappings are cleared, ch_req, grant, grant_vld and irq_summary are all zero.
- R2: A mapping register holds a valid flag in bit 7 and a channel number in bits [4:0]. An asserted request line whose flag is set drives ch_req of its channel in the same cycle. A line whose flag is clear drives nothing.
- R3: The register of line n is written at byte address 0x100 + 4·n when n < 64 and at 0x1100 + 4·(n − 64) otherwise. A write to any other address changes no mapping.
- R4: Writing zero to a mapping register removes the mapping, so the line no longer drives any channel.
- R5: When several request lines map to one channel, their requests are ORed into that channel.
- R6: grant is one-hot or zero, and grant_vld is high exactly when grant is non-zero. A grant appears on the clock edge after the request is seen on ch_req, and only for a channel that requested in the previous cycle.
- R7: The tier of a channel is its index bits [3:2], and tier 0 is the highest. A new grant goes to a requesting channel of the highest-priority tier that has a request.
- R8: Within a tier, a new grant goes to the first requesting channel of that tier found by counting upward, with wrap-around, from the last channel granted in that tier. After reset the search of each tier starts at channel 0.
- R9: A grant stays on its holder while that channel keeps requesting and burst_done is low, even if a higher tier starts to request. When the holder drops its request or burst_done is high, the next winner is granted on that same edge, or grant goes to zero if nothing requests.
- R10: irq_summary is a registered copy of ch_irq with one cycle of latency, one bit per channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Mapping register write strobe |
| cfg_addr | input | 13 | Byte address of the mapping register |
| cfg_wdata | input | 8 | Write data: bit 7 valid, bits [4:0] channel |
| periph_req | input | NUM_REQ | Peripheral request lines |
| burst_done | input | 1 | The current grant holder has finished its burst |
| ch_irq | input | NUM_CH | Per-channel interrupt pending |
| ch_req | output | NUM_CH | Routed per-channel requests |
| grant | output | NUM_CH | One-hot bus grant |
| grant_vld | output | 1 | A grant is active |
| irq_summary | output | NUM_CH | Registered interrupt summary |

## Verification
On every cycle the assertions check the following: the grant is one-hot and agrees with grant_vld, every grant was requested in the previous cycle, a held grant stays put while its owner keeps requesting without burst_done, no channel is driven while no mapping is valid, and the summary tracks the interrupt inputs one cycle late. The tier order, the rotation order inside a tier, the two address banks, rejected addresses, the OR-merge of shared channels and mapping removal depend on sequences of stimulus. Only the bench's directed scenarios show these, by comparing against expected channel numbers.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

  localparam int MAP_AW       = 13;
  localparam int MAP_VLD_BIT  = 7;
  localparam int MAP_CHF_W    = 5;
  localparam int BANK_LINES   = 64;
  localparam int LO_BANK_BASE = 'h100;
  localparam int HI_BANK_BASE = 'h1100;
  localparam int TIER_LSB     = 2;
  localparam int NUM_TIER     = 4;

  typedef struct packed {
    logic                 vld;
    logic [MAP_CHF_W-1:0] chn;
  } map_ent_t;

  function automatic logic [MAP_AW-1:0] map_addr(input int line);
    int base;
    base = (line < BANK_LINES) ? LO_BANK_BASE : HI_BANK_BASE;
    return MAP_AW'(base + 4 * (line % BANK_LINES));
  endfunction

  function automatic int tier_of(input int chn);
    return (chn >> TIER_LSB) % NUM_TIER;
  endfunction

endpackage

// File: rtl/dreq_map_regs.sv
module dreq_map_regs
  import dreq_pkg::*;
#(
  parameter int NUM_REQ = 72,
  parameter int NUM_CH  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MAP_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [NUM_REQ-1:0] line_req,
  output logic [NUM_CH-1:0]  route_req
);

  map_ent_t map_q [NUM_REQ];
  map_ent_t map_d [NUM_REQ];
  logic [NUM_REQ-1:0] hit;
  logic [NUM_REQ-1:0] vld_vec;
  logic unused_wdata;

  assign unused_wdata = ^wr_data[6:5];

  for (genvar n = 0; n < NUM_REQ; n++) begin : g_map
    assign hit[n]     = wr_en && (wr_addr == map_addr(n));
    assign vld_vec[n] = map_q[n].vld;

    always_comb begin
      map_d[n] = map_q[n];
      if (hit[n]) begin
        map_d[n].vld = wr_data[MAP_VLD_BIT];
        map_d[n].chn = wr_data[MAP_CHF_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[n] <= '0;
      end else if (hit[n]) begin
        map_q[n] <= map_d[n];
      end
    end
  end

  always_comb begin
    route_req = '0;
    for (int n = 0; n < NUM_REQ; n++) begin
      if (map_q[n].vld && line_req[n] && (int'(map_q[n].chn) < NUM_CH)) begin
        route_req[int'(map_q[n].chn)] = 1'b1;
      end
    end
  end

  // R2 / R4: with no valid mapping nothing may reach a channel
  a_r4_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_vec == '0) |-> (route_req == '0));

  // R3: at most one register decodes any write address
  a_r3_single_decode: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/dreq_tier_arb.sv
module dreq_tier_arb
  import dreq_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic              burst_done,
  output logic [NUM_CH-1:0] grant,
  output logic              grant_vld
);

  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [CH_W-1:0] holder_q, holder_d;
  logic            hvld_q, hvld_d;
  logic [CH_W-1:0] ptr_q [NUM_TIER];
  logic [CH_W-1:0] ptr_d [NUM_TIER];
  logic [NUM_TIER-1:0] ptr_en;
  logic [NUM_TIER-1:0] tier_found;
  logic [CH_W-1:0]     tier_pick [NUM_TIER];
  logic            keep;
  logic            win_found;
  logic [CH_W-1:0] win;

  // Per-tier rotating search, starting just after the tier's last winner
  for (genvar t = 0; t < NUM_TIER; t++) begin : g_tier
    always_comb begin
      int idx;
      tier_found[t] = 1'b0;
      tier_pick[t]  = '0;
      for (int k = 1; k <= NUM_CH; k++) begin
        idx = (int'(ptr_q[t]) + k) % NUM_CH;
        if (!tier_found[t] && req[idx] && (tier_of(idx) == t)) begin
          tier_found[t] = 1'b1;
          tier_pick[t]  = CH_W'(idx);
        end
      end
    end
  end

  // Highest-priority tier (lowest number) with a candidate wins
  always_comb begin
    win_found = 1'b0;
    win       = '0;
    for (int t = NUM_TIER - 1; t >= 0; t--) begin
      if (tier_found[t]) begin
        win_found = 1'b1;
        win       = tier_pick[t];
      end
    end
  end

  assign keep = hvld_q && req[holder_q] && !burst_done;

  always_comb begin
    holder_d = holder_q;
    hvld_d   = 1'b0;
    ptr_en   = '0;
    for (int t = 0; t < NUM_TIER; t++) ptr_d[t] = ptr_q[t];
    if (keep) begin
      hvld_d = 1'b1;
    end else if (win_found) begin
      hvld_d   = 1'b1;
      holder_d = win;
      ptr_en[tier_of(int'(win))] = 1'b1;
      ptr_d[tier_of(int'(win))]  = win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hvld_q   <= 1'b0;
      holder_q <= '0;
    end else begin
      hvld_q   <= hvld_d;
      holder_q <= holder_d;
    end
  end

  for (genvar t = 0; t < NUM_TIER; t++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[t] <= CH_W'(NUM_CH - 1);
      end else if (ptr_en[t]) begin
        ptr_q[t] <= ptr_d[t];
      end
    end
  end

  always_comb begin
    grant = '0;
    if (hvld_q) grant[holder_q] = 1'b1;
  end
  assign grant_vld = hvld_q;

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r6_vld_match: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld == (grant != '0));

  a_r6_was_requested: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((grant == '0) || ((grant & $past(req)) != '0)));

  a_r6_no_req_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |=> (grant == '0));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (((grant & req) != '0) && !burst_done) |=> $stable(grant));

endmodule

// File: rtl/dreq_irq_sum.sv
module dreq_irq_sum #(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] irq_in,
  output logic [NUM_CH-1:0] summary
);

  logic [NUM_CH-1:0] sum_q, sum_d;

  assign sum_d = irq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= '0;
    else        sum_q <= sum_d;
  end

  assign summary = sum_q;

  a_r10_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_in != '0) |=> (summary == $past(irq_in)));

endmodule

// File: rtl/dreq_prio_router.sv
module dreq_prio_router
  import dreq_pkg::*;
#(
  parameter int NUM_REQ = 72,
  parameter int NUM_CH  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [MAP_AW-1:0]  cfg_addr,
  input  logic [7:0]         cfg_wdata,
  input  logic [NUM_REQ-1:0] periph_req,
  input  logic               burst_done,
  input  logic [NUM_CH-1:0]  ch_irq,
  output logic [NUM_CH-1:0]  ch_req,
  output logic [NUM_CH-1:0]  grant,
  output logic               grant_vld,
  output logic [NUM_CH-1:0]  irq_summary
);

  dreq_map_regs #(.NUM_REQ(NUM_REQ), .NUM_CH(NUM_CH)) u_map (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_addr   (cfg_addr),
    .wr_data   (cfg_wdata),
    .line_req  (periph_req),
    .route_req (ch_req)
  );

  dreq_tier_arb #(.NUM_CH(NUM_CH)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (ch_req),
    .burst_done (burst_done),
    .grant      (grant),
    .grant_vld  (grant_vld)
  );

  dreq_irq_sum #(.NUM_CH(NUM_CH)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (ch_irq),
    .summary (irq_summary)
  );

endmodule

// File: tb/dreq_prio_router_tb_top.sv
module dreq_prio_router_tb_top;

  localparam int NREQ = 72;
  localparam int NCH  = 32;

  logic            clk;
  logic            rst_n;
  logic            cfg_wr_en;
  logic [12:0]     cfg_addr;
  logic [7:0]      cfg_wdata;
  logic [NREQ-1:0] periph_req;
  logic            burst_done;
  logic [NCH-1:0]  ch_irq;
  logic [NCH-1:0]  ch_req;
  logic [NCH-1:0]  grant;
  logic            grant_vld;
  logic [NCH-1:0]  irq_summary;

  int n_chk;
  int n_bad;

  dreq_prio_router #(.NUM_REQ(NREQ), .NUM_CH(NCH)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .periph_req  (periph_req),
    .burst_done  (burst_done),
    .ch_irq      (ch_irq),
    .ch_req      (ch_req),
    .grant       (grant),
    .grant_vld   (grant_vld),
    .irq_summary (irq_summary)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [12:0] line_addr(input int n);
    return (n < 64) ? 13'(32'h100 + 4 * n) : 13'(32'h1100 + 4 * (n - 64));
  endfunction

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [NCH-1:0] bit_of(input int c);
    logic [NCH-1:0] v;
    v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  task automatic set_chreq(input logic [NCH-1:0] v);
    periph_req = '0;
    periph_req[NCH-1:0] = v;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 grant in reset", 64'(grant), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    periph_req = '1;
    #1;
    chk("R1 ch_req cleared maps", 64'(ch_req), 64'h0);
    chk("R1 grant_vld", 64'(grant_vld), 64'h0);
    chk("R1 irq_summary", 64'(irq_summary), 64'h0);
    periph_req = '0;
  endtask

  task automatic t_mapping;
    wr(line_addr(3), 8'h85);
    periph_req[3] = 1'b1;
    #1 chk("R2 line3 to ch5", 64'(ch_req), 64'(bit_of(5)));
    wr(line_addr(4), 8'h05);
    periph_req[4] = 1'b1;
    #1 chk("R2 invalid map ignored", 64'(ch_req), 64'(bit_of(5)));
    wr(13'h1104, 8'h8A);
    periph_req[65] = 1'b1;
    #1 chk("R3 upper bank line65 to ch10", 64'(ch_req), 64'(bit_of(5) | bit_of(10)));
    periph_req[65] = 1'b0;
    wr(13'h0101, 8'h80);
    periph_req[0] = 1'b1;
    #1 chk("R3 misaligned write ignored", 64'(ch_req), 64'(bit_of(5)));
    periph_req[0] = 1'b0;
    wr(line_addr(6), 8'h85);
    periph_req[3] = 1'b0;
    periph_req[6] = 1'b1;
    #1 chk("R5 second line drives ch5", 64'(ch_req), 64'(bit_of(5)));
    periph_req[3] = 1'b1;
    #1 chk("R5 both lines ORed", 64'(ch_req), 64'(bit_of(5)));
    wr(line_addr(3), 8'h00);
    #1 chk("R4 line6 still maps", 64'(ch_req), 64'(bit_of(5)));
    wr(line_addr(6), 8'h00);
    #1 chk("R4 zero write removes map", 64'(ch_req), 64'h0);
    periph_req = '0;
    @(negedge clk);
  endtask

  task automatic t_map_identity;
    for (int k = 0; k < NCH; k++) wr(line_addr(k), 8'(8'h80 | k));
    set_chreq(bit_of(9));
    #1 chk("R2 identity map ch9", 64'(ch_req), 64'(bit_of(9)));
    set_chreq('0);
    @(negedge clk);
  endtask

  task automatic t_tiers;
    set_chreq(bit_of(4) | bit_of(8) | bit_of(17));
    #1 chk("R6 no grant before edge", 64'(grant), 64'h0);
    @(negedge clk);
    chk("R7 tier0 ch17 wins", 64'(grant), 64'(bit_of(17)));
    chk("R6 grant_vld high", 64'(grant_vld), 64'h1);
    set_chreq('0);
    @(negedge clk);
    chk("R9 release to idle", 64'(grant), 64'h0);
    chk("R6 grant_vld low", 64'(grant_vld), 64'h0);
    set_chreq(bit_of(5) | bit_of(9) | bit_of(13));
    @(negedge clk);
    chk("R7 tier1 ch5 wins", 64'(grant), 64'(bit_of(5)));
    set_chreq('0);
    @(negedge clk);
  endtask

  task automatic pulse_done;
    burst_done = 1'b1;
    @(negedge clk);
    burst_done = 1'b0;
  endtask

  task automatic t_rotate;
    set_chreq(bit_of(0) | bit_of(1) | bit_of(16));
    @(negedge clk);
    chk("R8 after ch17 rotates to ch0", 64'(grant), 64'(bit_of(0)));
    pulse_done();
    chk("R8 next ch1", 64'(grant), 64'(bit_of(1)));
    pulse_done();
    chk("R8 next ch16", 64'(grant), 64'(bit_of(16)));
    pulse_done();
    chk("R8 wrap to ch0", 64'(grant), 64'(bit_of(0)));
    repeat (3) @(negedge clk);
    chk("R9 held without done", 64'(grant), 64'(bit_of(0)));
    set_chreq(bit_of(1) | bit_of(16));
    @(negedge clk);
    chk("R9 drop moves to ch1", 64'(grant), 64'(bit_of(1)));
    set_chreq('0);
    @(negedge clk);
  endtask

  task automatic t_no_preempt;
    set_chreq(bit_of(12));
    @(negedge clk);
    chk("R7 tier3 alone wins", 64'(grant), 64'(bit_of(12)));
    set_chreq(bit_of(12) | bit_of(3));
    @(negedge clk);
    chk("R9 no preemption", 64'(grant), 64'(bit_of(12)));
    pulse_done();
    chk("R7 tier0 after done", 64'(grant), 64'(bit_of(3)));
    set_chreq('0);
    @(negedge clk);
  endtask

  task automatic t_irq;
    ch_irq = 32'h0000_00A5;
    #1 chk("R10 one cycle latency", 64'(irq_summary), 64'h0);
    @(negedge clk);
    chk("R10 summary follows", 64'(irq_summary), 64'hA5);
    ch_irq = 32'h8000_0001;
    @(negedge clk);
    chk("R10 summary update", 64'(irq_summary), 64'h8000_0001);
    ch_irq = '0;
    @(negedge clk);
    chk("R10 summary clears", 64'(irq_summary), 64'h0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    cfg_wr_en = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    periph_req = '0;
    burst_done = 1'b0;
    ch_irq = '0;
    t_reset();
    t_mapping();
    t_map_identity();
    t_tiers();
    t_rotate();
    t_no_preempt();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule